// File: doc/BRIEF.md
# Retired-Instruction Counter Register Bank

This block holds the 64-bit count of retired instructions and answers every control-register address that belongs to the counter group. A processor core pulses `retire_i` once for each instruction that completes. It presents a 12-bit register address with a write strobe and write data. In the same cycle it gets back the read data and a flag that says whether the address belongs to this bank. A single input, `xlen32_i`, selects a 32-bit or a 64-bit register width.

The cycle counter is not a separate register. Its machine address and the retired-instruction machine address both reach the one 64-bit counter, for reads and for writes. User-level read-only copies of the counter are decoded as well. The bank also holds 29 programmable performance counters with their event selectors, and an inhibit register. The performance counters never count on their own. Privilege checks and trap generation happen outside this block, so a write to a read-only address is simply dropped.

Top module: `csr_ctr_bank`

## Requirements
- R1: A synchronous active-high reset clears the counter, every performance counter, every event selector and the inhibit register to zero.
- R2: Each cycle with `retire_i` high and no counter write adds one to the counter. The count wraps from all ones to zero. With no retire and no write, the counter holds its value.
- R3: A write to the counter in the same cycle as a retire leaves exactly the written value, with no increment added.
- R4: Addresses 0xB00 (cycle alias) and 0xB02 (instret) reach the same 64-bit counter, for both reads and writes. With a 32-bit width, their upper halves 0xB80 and 0xB82 are likewise shared.
- R5: With a 64-bit width, a write to a low address replaces all 64 bits and a read returns all 64 bits. With a 32-bit width, a low write replaces bits 31:0 and keeps bits 63:32, and a low read returns bits 31:0 zero-extended. An upper-half write replaces bits 63:32 and keeps bits 31:0, and an upper-half read returns bits 63:32 in bits 31:0.
- R6: Upper-half addresses (bit 7 set, in the 0xB or 0xC group) are recognised only with a 32-bit width. With a 64-bit width they return `hit_o`=0 and zero data, and writes to them change nothing.
- R7: User addresses 0xC00 and 0xC02 (and 0xC80/0xC82 with a 32-bit width) read the counter with the same width rules. Writes to them are ignored.
- R8: Performance counter n (3..31) sits at 0xB00+n, with its upper half at 0xB80+n. It is a writable register that retires do not change. Its user copy at 0xC00+n (0xC80+n) reads the same value and ignores writes.
- R9: Event selector n (3..31) at 0x320+n and the 32-bit inhibit register at 0x320 are writable and read back what was written. The event selectors follow the low-address width rules of R5.
- R10: Every other address returns `hit_o`=0 and zero read data, including 0xB01, 0xC01, 0x321, 0x322, 0xB20 and 0x7C0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| xlen32_i | input | 1 | 1 selects the 32-bit register width, 0 the 64-bit width |
| retire_i | input | 1 | One instruction retired this cycle |
| addr_i | input | 12 | Register address |
| we_i | input | 1 | Write strobe for `addr_i` |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i`, combinational |
| hit_o | output | 1 | `addr_i` belongs to the counter bank |

## Verification
The checker decodes the counter addresses itself and assumes that `addr_i`, `we_i` and `wdata_i` stay stable for a whole cycle. It also assumes that `xlen32_i` during a write cycle is the setting the write is meant to use. The stimulus changes all inputs only at the falling clock edge. It holds the width setting for long runs of several hundred cycles and moves between them. Random operations are drawn from a pool that covers every decoded group, the upper halves and the unused holes, so writes to missing or read-only addresses occur often.

// File: rtl/csr_ctr_pkg.sv
package csr_ctr_pkg;

  localparam int CNT_W  = 64;
  localparam int HALF_W = CNT_W / 2;
  localparam int ADDR_W = 12;
  localparam int INH_W  = 32;
  localparam int SLOT_W = 5;
  localparam int HPM_BASE = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RET,
    SEL_RET_RO,
    SEL_HPM,
    SEL_HPM_RO,
    SEL_EVT,
    SEL_INH
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e          kind;
    logic               upper;
    logic [SLOT_W-1:0]  slot;
  } sel_t;

  // New register value after a write through a low or upper-half address.
  function automatic logic [CNT_W-1:0] merge_write(
      input logic [CNT_W-1:0] old_v,
      input logic [CNT_W-1:0] wd,
      input logic             upper,
      input logic             x32);
    if (upper)
      return {wd[HALF_W-1:0], old_v[HALF_W-1:0]};
    else if (x32)
      return {old_v[CNT_W-1:HALF_W], wd[HALF_W-1:0]};
    else
      return wd;
  endfunction

  // Value presented on the read port for a register value.
  function automatic logic [CNT_W-1:0] read_view(
      input logic [CNT_W-1:0] v,
      input logic             upper,
      input logic             x32);
    if (upper)
      return {{HALF_W{1'b0}}, v[CNT_W-1:HALF_W]};
    else if (x32)
      return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
    else
      return v;
  endfunction

endpackage

// File: rtl/csr_ctr_decode.sv
module csr_ctr_decode
  import csr_ctr_pkg::*;
#(
  parameter int HPM_COUNT = 29
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              xlen32_i,
  output sel_t              sel_o
);
  localparam logic [5:0] SLOT_LIM = 6'(HPM_BASE + HPM_COUNT);

  logic [4:0] n;
  logic       in_range;
  logic       is_ret;
  logic       shape_ok;

  assign n        = addr_i[4:0];
  assign in_range = ({1'b0, n} >= 6'(HPM_BASE)) && ({1'b0, n} < SLOT_LIM);
  assign is_ret   = (n == 5'd0) || (n == 5'd2);
  assign shape_ok = (addr_i[6:5] == 2'b00) && (!addr_i[7] || xlen32_i);

  always_comb begin
    sel_o.kind  = SEL_NONE;
    sel_o.upper = 1'b0;
    sel_o.slot  = n - 5'(HPM_BASE);
    unique case (addr_i[11:8])
      4'hB, 4'hC: begin
        if (shape_ok) begin
          sel_o.upper = addr_i[7];
          if (is_ret)
            sel_o.kind = (addr_i[8]) ? SEL_RET : SEL_RET_RO;
          else if (in_range)
            sel_o.kind = (addr_i[8]) ? SEL_HPM : SEL_HPM_RO;
        end
      end
      4'h3: begin
        if (addr_i[7:5] == 3'b001) begin
          if (n == 5'd0)
            sel_o.kind = SEL_INH;
          else if (in_range)
            sel_o.kind = SEL_EVT;
        end
      end
      default: sel_o.kind = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/csr_ret_counter.sv
module csr_ret_counter
  import csr_ctr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             retire_i,
  input  logic             wr_i,
  input  logic             upper_i,
  input  logic             xlen32_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             inc_fire;
  logic [CNT_W-1:0] wr_value;

  // A write suppresses the increment of the same cycle.
  assign inc_fire = retire_i && !wr_i;
  assign wr_value = merge_write(cnt_o, wdata_i, upper_i, xlen32_i);

  always_ff @(posedge clk_i) begin
    if (rst_i)
      cnt_o <= '0;
    else if (wr_i)
      cnt_o <= wr_value;
    else if (inc_fire)
      cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/csr_hpm_bank.sv
module csr_hpm_bank
  import csr_ctr_pkg::*;
#(
  parameter int HPM_COUNT = 29
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_cnt_i,
  input  logic              wr_evt_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              upper_i,
  input  logic              xlen32_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_sel_o,
  output logic [CNT_W-1:0]  evt_sel_o
);
  logic [CNT_W-1:0] cnt_q [HPM_COUNT];
  logic [CNT_W-1:0] evt_q [HPM_COUNT];

  for (genvar g = 0; g < HPM_COUNT; g++) begin : g_slot
    logic hit_slot;
    assign hit_slot = (slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i) begin
      if (rst_i)
        cnt_q[g] <= '0;
      else if (wr_cnt_i && hit_slot)
        cnt_q[g] <= merge_write(cnt_q[g], wdata_i, upper_i, xlen32_i);
    end

    always_ff @(posedge clk_i) begin
      if (rst_i)
        evt_q[g] <= '0;
      else if (wr_evt_i && hit_slot)
        evt_q[g] <= merge_write(evt_q[g], wdata_i, 1'b0, xlen32_i);
    end
  end

  always_comb begin
    cnt_sel_o = '0;
    evt_sel_o = '0;
    for (int i = 0; i < HPM_COUNT; i++) begin
      if (slot_i == SLOT_W'(i)) begin
        cnt_sel_o = cnt_q[i];
        evt_sel_o = evt_q[i];
      end
    end
  end
endmodule

// File: rtl/csr_ctr_bank.sv
module csr_ctr_bank
  import csr_ctr_pkg::*;
#(
  parameter int HPM_COUNT = 29
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              xlen32_i,
  input  logic              retire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              hit_o
);
  sel_t             sel;
  logic             ret_wr;
  logic             hpm_wr;
  logic             evt_wr;
  logic             inh_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hpm_val;
  logic [CNT_W-1:0] evt_val;
  logic [INH_W-1:0] inh_q;
  logic [CNT_W-1:0] src_val;

  csr_ctr_decode #(.HPM_COUNT(HPM_COUNT)) u_dec (
    .addr_i   (addr_i),
    .xlen32_i (xlen32_i),
    .sel_o    (sel)
  );

  assign ret_wr = we_i && (sel.kind == SEL_RET);
  assign hpm_wr = we_i && (sel.kind == SEL_HPM);
  assign evt_wr = we_i && (sel.kind == SEL_EVT);
  assign inh_wr = we_i && (sel.kind == SEL_INH);

  csr_ret_counter u_cnt (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .retire_i (retire_i),
    .wr_i     (ret_wr),
    .upper_i  (sel.upper),
    .xlen32_i (xlen32_i),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt_q)
  );

  csr_hpm_bank #(.HPM_COUNT(HPM_COUNT)) u_hpm (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_cnt_i  (hpm_wr),
    .wr_evt_i  (evt_wr),
    .slot_i    (sel.slot),
    .upper_i   (sel.upper),
    .xlen32_i  (xlen32_i),
    .wdata_i   (wdata_i),
    .cnt_sel_o (hpm_val),
    .evt_sel_o (evt_val)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)
      inh_q <= '0;
    else if (inh_wr)
      inh_q <= wdata_i[INH_W-1:0];
  end

  always_comb begin
    unique case (sel.kind)
      SEL_RET, SEL_RET_RO: src_val = cnt_q;
      SEL_HPM, SEL_HPM_RO: src_val = hpm_val;
      SEL_EVT:             src_val = evt_val;
      SEL_INH:             src_val = {{(CNT_W-INH_W){1'b0}}, inh_q};
      default:             src_val = '0;
    endcase
  end

  assign hit_o   = (sel.kind != SEL_NONE);
  assign rdata_o = hit_o ? read_view(src_val, sel.upper, xlen32_i) : '0;
endmodule

// File: rtl/csr_ctr_chk.sv
module csr_ctr_chk (
  input logic        clk_i,
  input logic        rst_i,
  input logic        xlen32_i,
  input logic        retire_i,
  input logic [11:0] addr_i,
  input logic        we_i,
  input logic [63:0] wdata_i,
  input logic [63:0] rdata_o,
  input logic        hit_o,
  input logic [63:0] cnt
);
  logic lo_addr;
  logic hi_addr;
  logic cnt_wr;
  logic hi_group;

  assign lo_addr  = (addr_i == 12'hB00) || (addr_i == 12'hB02);
  assign hi_addr  = xlen32_i && ((addr_i == 12'hB80) || (addr_i == 12'hB82));
  assign cnt_wr   = we_i && (lo_addr || hi_addr);
  assign hi_group = addr_i[7] && ((addr_i[11:8] == 4'hB) || (addr_i[11:8] == 4'hC));

  // R1
  p_reset_clears_r1: assert property (@(posedge clk_i)
    rst_i |=> cnt == 64'd0);

  p_count_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cnt_wr && retire_i) |=> cnt == $past(cnt) + 64'd1);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cnt_wr && !retire_i) |=> cnt == $past(cnt));

  p_write_wins_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && lo_addr && !xlen32_i) |=> cnt == $past(wdata_i));

  p_low_half_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && lo_addr && xlen32_i) |=>
      cnt == {$past(cnt[63:32]), $past(wdata_i[31:0])});

  p_high_half_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && hi_addr) |=>
      cnt == {$past(wdata_i[31:0]), $past(cnt[31:0])});

  p_no_upper_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!xlen32_i && hi_group) |-> (!hit_o && rdata_o == 64'd0));

  p_shadow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_i == 12'hC02 && !xlen32_i) |-> (hit_o && rdata_o == cnt));
endmodule

bind csr_ctr_bank csr_ctr_chk u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .xlen32_i (xlen32_i),
  .retire_i (retire_i),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .hit_o    (hit_o),
  .cnt      (cnt_q)
);

// File: tb/tb_csr_ctr_bank.sv
module tb_csr_ctr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        x32 = 1'b0;
  logic        retire = 1'b0;
  logic [11:0] addr = 12'h000;
  logic        we = 1'b0;
  logic [63:0] wdata = 64'd0;
  logic [63:0] rdata;
  logic        hit;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_cnt;
  logic [63:0] m_hpm [29];
  logic [63:0] m_evt [29];
  logic [31:0] m_inh;

  always #5 clk = ~clk;

  csr_ctr_bank dut (
    .clk_i(clk), .rst_i(rst), .xlen32_i(x32), .retire_i(retire),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .hit_o(hit)
  );

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired: act=running exp=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [63:0] wmerge(logic [63:0] old_v, logic [63:0] wd,
                                         logic up, logic w32);
    logic [63:0] lo_mask = 64'h0000_0000_FFFF_FFFF;
    if (up) return (old_v & lo_mask) | (wd << 32);
    if (w32) return (old_v & ~lo_mask) | (wd & lo_mask);
    return wd;
  endfunction

  function automatic logic [64:0] exp_rd(logic [11:0] a, logic w32);
    logic [63:0] v = 64'd0;
    logic up = a[7];
    int n = int'(a[4:0]);
    logic found = 1'b0;
    if ((a[11:8] == 4'hB || a[11:8] == 4'hC) && a[6:5] == 2'b00 && (!up || w32)) begin
      if (n == 0 || n == 2) begin v = m_cnt; found = 1'b1; end
      else if (n >= 3) begin v = m_hpm[n-3]; found = 1'b1; end
    end else if (a[11:5] == 7'b0011001) begin
      up = 1'b0;
      if (n == 0) begin v = {32'd0, m_inh}; found = 1'b1; end
      else if (n >= 3) begin v = m_evt[n-3]; found = 1'b1; end
    end
    if (!found) return 65'd0;
    if (up) v = v >> 32;
    else if (w32) v = v & 64'h0000_0000_FFFF_FFFF;
    return {1'b1, v};
  endfunction

  task automatic model_clear();
    m_cnt = 64'd0;
    m_inh = 32'd0;
    for (int i = 0; i < 29; i++) begin m_hpm[i] = 64'd0; m_evt[i] = 64'd0; end
  endtask

  task automatic model_step(logic [11:0] a, logic w, logic [63:0] wd, logic r, logic w32);
    logic cnt_hit = 1'b0;
    int n = int'(a[4:0]);
    if (w && a[11:8] == 4'hB && a[6:5] == 2'b00 && (!a[7] || w32)) begin
      if (n == 0 || n == 2) begin m_cnt = wmerge(m_cnt, wd, a[7], w32); cnt_hit = 1'b1; end
      else if (n >= 3) m_hpm[n-3] = wmerge(m_hpm[n-3], wd, a[7], w32);
    end else if (w && a[11:5] == 7'b0011001) begin
      if (n == 0) m_inh = wd[31:0];
      else if (n >= 3) m_evt[n-3] = wmerge(m_evt[n-3], wd, 1'b0, w32);
    end
    if (!cnt_hit && r) m_cnt = m_cnt + 64'd1;
  endtask

  task automatic step(logic [11:0] a, logic w, logic [63:0] wd, logic r);
    @(negedge clk);
    addr = a; we = w; wdata = wd; retire = r;
    @(posedge clk);
    model_step(a, w, wd, r, x32);
  endtask

  task automatic check(logic [11:0] a, string tag);
    logic [64:0] e;
    @(negedge clk);
    addr = a; we = 1'b0; retire = 1'b0;
    #1;
    e = exp_rd(a, x32);
    checks++;
    if (hit !== e[64] || rdata !== e[63:0]) begin
      fails++;
      $display("FAIL %s addr=%h x32=%0d act hit=%0d data=%h exp hit=%0d data=%h",
               tag, a, x32, hit, rdata, e[64], e[63:0]);
    end
  endtask

  function automatic logic [11:0] pick(int k);
    case (k)
      0: return 12'hB00;  1: return 12'hB02;  2: return 12'hB80;  3: return 12'hB82;
      4: return 12'hC00;  5: return 12'hC02;  6: return 12'hC80;  7: return 12'hC82;
      8: return 12'hB03;  9: return 12'hB10; 10: return 12'hB1F; 11: return 12'hB83;
      12: return 12'hB9F; 13: return 12'hC03; 14: return 12'hC1F; 15: return 12'hC83;
      16: return 12'h323; 17: return 12'h33F; 18: return 12'h320; 19: return 12'h321;
      20: return 12'hB01; 21: return 12'hC01; 22: return 12'hB20; 23: return 12'hBA0;
      24: return 12'hC20; 25: return 12'h7C0; default: return 12'h000;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2718));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(12'hB02, "R1 counter");
    check(12'hC00, "R1 shadow");
    check(12'hB03, "R1 hpm");
    check(12'h323, "R1 event");
    check(12'h320, "R1 inhibit");

    // R2 counting, R4 alias
    step(12'h000, 1'b0, 64'd0, 1'b1);
    step(12'h000, 1'b0, 64'd0, 1'b1);
    step(12'h000, 1'b0, 64'd0, 1'b1);
    check(12'hB02, "R2 three retires");
    check(12'hB00, "R4 alias read");

    // R3 write wins, R4 alias write
    step(12'hB00, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b1);
    check(12'hB02, "R3 write over retire");
    check(12'hB00, "R4 alias after write");

    // R2 wrap
    step(12'hB02, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    step(12'h000, 1'b0, 64'd0, 1'b1);
    check(12'hB02, "R2 wrap to zero");

    // R6 upper half absent in 64-bit
    step(12'hB02, 1'b1, 64'h0000_0001_0000_0005, 1'b0);
    step(12'hB82, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0);
    check(12'hB82, "R6 upper miss");
    check(12'hB02, "R6 counter unchanged");

    // R7 shadow write ignored
    step(12'hC02, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
    check(12'hC02, "R7 shadow read");
    check(12'hB02, "R7 write ignored");

    // R5 32-bit halves
    x32 = 1'b1;
    step(12'hB82, 1'b1, 64'hFFFF_FFFF_CAFE_0001, 1'b1);
    check(12'hB82, "R5 upper write");
    check(12'hB02, "R5 low keeps");
    step(12'hB02, 1'b1, 64'h5555_5555_0BAD_F00D, 1'b1);
    check(12'hB82, "R5 upper kept");
    check(12'hB00, "R5 low write");
    check(12'hC82, "R7 upper shadow");
    check(12'hB80, "R4 upper alias");

    // R8 performance counters
    step(12'hB85, 1'b1, 64'h0000_0000_0000_0077, 1'b0);
    step(12'hB05, 1'b1, 64'h0000_0000_0000_1111, 1'b1);
    step(12'h000, 1'b0, 64'd0, 1'b1);
    check(12'hB05, "R8 hpm low");
    check(12'hC85, "R8 hpm shadow upper");
    step(12'hC05, 1'b1, 64'h9999_9999_9999_9999, 1'b0);
    check(12'hC05, "R8 shadow write ignored");

    // R9 events and inhibit
    step(12'h330, 1'b1, 64'h0000_0000_ABCD_0123, 1'b0);
    step(12'h320, 1'b1, 64'h0000_0000_0000_0005, 1'b0);
    check(12'h330, "R9 event");
    check(12'h320, "R9 inhibit");
    x32 = 1'b0;
    step(12'h33F, 1'b1, 64'h8765_4321_0FED_CBA9, 1'b0);
    check(12'h33F, "R9 event 64-bit");

    // R10 holes
    step(12'hB01, 1'b1, 64'h1, 1'b0);
    check(12'hB01, "R10 hole B01");
    check(12'hC01, "R10 hole C01");
    check(12'h321, "R10 hole 321");
    check(12'h322, "R10 hole 322");
    check(12'hB20, "R10 hole B20");
    check(12'h7C0, "R10 hole 7C0");
    check(12'hB02, "R10 counter unchanged");

    // Random mix (R2..R10)
    for (int it = 0; it < 3000; it++) begin
      if (it % 500 == 0) x32 = ~x32;
      step(pick(int'($urandom_range(0, 26))), 1'($urandom),
           {$urandom, $urandom}, 1'($urandom));
      check(pick(int'($urandom_range(0, 26))), "R2-mix random R5 R7 R8 R9 R10");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule